// File: doc/BRIEF.md
# Host Bus Master for a Streaming Sampling Converter

This block sits on the host side of a parallel bus to a sampling converter. It drives chip select, read and write strobes toward the converter, so the host logic never has to sequence those strobes itself. A request carries a command, a bus-width choice, a synchronisation choice and an acquisition code. The block packs them into one configuration byte and writes that byte once the converter's active-low ready line allows it. For a start command it then keeps the converter running back to back. It reads each finished result, rebuilds the 13-bit value from one or two bus transfers, and offers the value on a valid/ready stream.

Reads are timed so that the converter is never accessed while it converts. The last read of every sample also starts the next conversion. The bus therefore stays quiet from that read until ready falls again. If the consumer stalls, that last read waits, and the next conversion start waits with it, so no sample is lost. A stop request lets the conversion in flight complete. The block then puts the converter into standby, collects the pending result without starting another conversion, and returns to idle.

Top module: `conv_host_ctrl`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high, `out_valid` is low and `cfg_ready` is high.
- R2: The configuration write begins only while `bus_rdy_n` is low, or while the converter is in standby. Standby is assumed after reset and after any standby write. A request that arrives while ready is high outside standby is held back until ready falls.
- R3: Each bus transfer holds its strobe low for `STROBE_CYC` cycles. Chip select falls one cycle before the strobe and rises one cycle after it. Read and write strobes are never low together.
- R4: The configuration byte is laid out as opcode in bits [7:4], width in bit [3] (1 = 13-bit bus), sync in bit [2] and acquisition code in bits [1:0]. Exactly one write is made per accepted request. The opcodes are start = 8, calibrate = 1, zero = 2 and standby = 11.
- R5: After a start write, no read occurs until `bus_rdy_n` is seen low. After a calibrate or zero write, `cfg_ready` returns only after ready has been seen high and then low.
- R6: Streaming begins with launch reads (two on an 8-bit bus, one on a 13-bit bus) that produce no output. Each later sample costs the same number of reads.
- R7: On the 8-bit bus, the first read of a sample gives result bits [7:0] from `bus_rdata[7:0]`. The second read gives result bits [12:8] from `bus_rdata[4:0]`. All other read bits are ignored.
- R8: On the 13-bit bus, one read gives the whole result from `bus_rdata[12:0]`.
- R9: Outside standby, no read begins while `bus_rdy_n` is high, so the bus is idle during each conversion.
- R10: `out_data` stays stable while `out_valid` is high and `out_ready` is low. The final read of the next sample is deferred until the held result is taken, and every conversion's result is delivered once and in order.
- R11: After a stop request, the conversion in flight completes. A standby write (opcode 11) follows, then that result is read and delivered with no further conversion start, and `cfg_ready` returns.
- R12: The sync choice only sets bit [2] of the configuration byte. The read schedule and the results are the same in either setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration request present |
| cfg_ready | output | 1 | Block idle, request taken |
| cfg_opcode | input | 4 | Command code |
| cfg_wide | input | 1 | 1 = 13-bit bus transfers, 0 = byte transfers |
| cfg_sync | input | 1 | Externally synchronised sampling choice |
| cfg_acq | input | 2 | Acquisition-time code |
| stop_req | input | 1 | Pulse: finish streaming and enter standby |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 13 | Reassembled signed result |
| bus_cs_n | output | 1 | Converter chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_wdata | output | 8 | Configuration byte |
| bus_rdata | input | 13 | Read data from the converter |
| bus_rdy_n | input | 1 | Converter ready, active low |

## Verification
The bench runs both bus widths and both sync settings against a converter model, with several consumer stall rates. A design that skipped the launch reads, or published them, would shift every result by one place. Swapping the byte order, or letting the upper junk bits through, corrupts 8-bit values. A stop handled by a plain read, or with the standby write missing, shows up as an extra conversion start, or as a converter left awake with the last sample lost. Holding the ready line high outside standby tests that the write is held back, and a calibrate command tests that idle is not reported while the calibration is still running.

// File: rtl/conv_host_pkg.sv
// Shared types and codes for the converter host bus master.
// Assumes a converter that decodes an 8-bit configuration byte.
package conv_host_pkg;
    localparam int OP_W  = 4;
    localparam int CFG_W = 8;

    localparam logic [OP_W-1:0] OPC_CAL     = 4'h1;
    localparam logic [OP_W-1:0] OPC_ZERO    = 4'h2;
    localparam logic [OP_W-1:0] OPC_START   = 4'h8;
    localparam logic [OP_W-1:0] OPC_STANDBY = 4'hB;

    // Byte layout decoded by the converter: opcode, width, sync, acquisition.
    typedef struct packed {
        logic [OP_W-1:0] opcode;
        logic            wide;
        logic            sync;
        logic [1:0]      acq;
    } cfg_word_t;

    typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD} bus_phase_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_GATE, ST_WRITE, ST_WAITHI, ST_WAITLO,
        ST_RDLO, ST_HOLD, ST_RDLAST, ST_STOPWR
    } ctl_state_t;
endpackage

// File: rtl/conv_bus_strobe.sv
// One bus transfer per go pulse. Chip select leads and trails the strobe by
// one cycle, and the strobe lasts STROBE_CYC cycles. Read data is captured
// on the last strobe cycle. Assumes go only while idle is high.
module conv_bus_strobe
    import conv_host_pkg::*;
#(
    parameter int STROBE_CYC = 2,
    parameter int DATA_W     = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              is_write,
    input  logic [DATA_W-1:0] rdata,
    output logic              idle,
    output logic              done,
    output logic              cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYC - 1);

    bus_phase_t       phase;
    logic [CNT_W-1:0] cnt;
    logic             wr_sel;

    assign idle = (phase == B_IDLE);

    // Transfer sequencer: select, strobe, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= B_IDLE;
            cnt     <= '0;
            wr_sel  <= 1'b0;
            cs_n    <= 1'b1;
            rd_n    <= 1'b1;
            wr_n    <= 1'b1;
            done    <= 1'b0;
            rdata_q <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                B_IDLE: if (go) begin
                    cs_n   <= 1'b0;
                    wr_sel <= is_write;
                    phase  <= B_SETUP;
                end
                B_SETUP: begin
                    rd_n  <= wr_sel;
                    wr_n  <= !wr_sel;
                    cnt   <= '0;
                    phase <= B_STROBE;
                end
                B_STROBE: if (cnt == LAST) begin
                    rd_n  <= 1'b1;
                    wr_n  <= 1'b1;
                    if (!wr_sel) rdata_q <= rdata;
                    phase <= B_HOLD;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: begin
                    cs_n  <= 1'b1;
                    done  <= 1'b1;
                    phase <= B_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/conv_result_pack.sv
// Rebuilds the result from one wide read or from a low byte plus an upper
// field, and holds it on a valid/ready output. Assumes last_we with publish
// only arrives while the output is empty.
module conv_result_pack #(
    parameter int DATA_W = 13,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic [DATA_W-1:0] rdata,
    input  logic              lo_we,
    input  logic              last_we,
    input  logic              publish,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic [BYTE_W-1:0] lo_q;
    logic [DATA_W-1:0] assembled;

    // Select the wide word or the byte pair.
    always_comb assembled = wide ? rdata : {rdata[HI_W-1:0], lo_q};

    // Low-byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (lo_we) lo_q <= rdata[BYTE_W-1:0];
    end

    // Output register with handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (last_we && publish) begin
            out_valid <= 1'b1;
            out_data  <= assembled;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/conv_host_ctrl.sv
// Top: takes a configuration request, writes it when the converter is ready
// or in standby, then streams results. The last read of every sample
// restarts the converter. Assumes the converter raises ready within one
// cycle of the rising edge of a start-triggering read.
module conv_host_ctrl
    import conv_host_pkg::*;
#(
    parameter int DATA_W     = 13,
    parameter int BYTE_W     = 8,
    parameter int STROBE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic [OP_W-1:0]   cfg_opcode,
    input  logic              cfg_wide,
    input  logic              cfg_sync,
    input  logic [1:0]        cfg_acq,
    input  logic              stop_req,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [CFG_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rdy_n
);
    ctl_state_t        state;
    cfg_word_t         cfg_q, stby_word;
    logic              standby_q, first_q, stop_q, final_q;
    logic              eng_go, eng_wr, eng_idle, eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic              bus_state, is_start;

    assign cfg_ready = (state == ST_IDLE);
    assign is_start  = (cfg_q.opcode == OPC_START);

    // Start one transfer when entering a bus state.
    always_comb begin
        bus_state = (state == ST_WRITE) || (state == ST_STOPWR) ||
                    (state == ST_RDLO)  || (state == ST_RDLAST);
        eng_wr    = (state == ST_WRITE) || (state == ST_STOPWR);
        eng_go    = bus_state && eng_idle && !eng_done;
    end

    // Standby byte keeps the other fields of the request.
    always_comb begin
        stby_word        = cfg_q;
        stby_word.opcode = OPC_STANDBY;
        bus_wdata        = (state == ST_STOPWR) ? stby_word : cfg_q;
    end

    // Command and streaming sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cfg_q     <= '0;
            standby_q <= 1'b1;
            first_q   <= 1'b0;
            stop_q    <= 1'b0;
            final_q   <= 1'b0;
        end else begin
            if (state == ST_IDLE) stop_q <= 1'b0;
            else if (stop_req)    stop_q <= 1'b1;
            case (state)
                ST_IDLE: if (cfg_valid) begin
                    cfg_q <= '{opcode: cfg_opcode, wide: cfg_wide,
                               sync: cfg_sync, acq: cfg_acq};
                    state <= ST_GATE;
                end
                ST_GATE: if (!bus_rdy_n || standby_q) state <= ST_WRITE;
                ST_WRITE: if (eng_done) begin
                    standby_q <= (cfg_q.opcode == OPC_STANDBY);
                    first_q   <= 1'b1;
                    final_q   <= 1'b0;
                    if (is_start)                         state <= ST_WAITLO;
                    else if (cfg_q.opcode == OPC_STANDBY) state <= ST_IDLE;
                    else                                  state <= ST_WAITHI;
                end
                ST_WAITHI: if (bus_rdy_n) state <= ST_WAITLO;
                ST_WAITLO: if (!bus_rdy_n) begin
                    if (!is_start)              state <= ST_IDLE;
                    else if (stop_q && !first_q) state <= ST_STOPWR;
                    else                        state <= cfg_q.wide ? ST_HOLD : ST_RDLO;
                end
                ST_STOPWR: if (eng_done) begin
                    standby_q <= 1'b1;
                    final_q   <= 1'b1;
                    state     <= cfg_q.wide ? ST_HOLD : ST_RDLO;
                end
                ST_RDLO: if (eng_done) state <= ST_HOLD;
                ST_HOLD: if (first_q || !out_valid) state <= ST_RDLAST;
                ST_RDLAST: if (eng_done) begin
                    first_q <= 1'b0;
                    state   <= final_q ? ST_IDLE : ST_WAITLO;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    conv_bus_strobe #(.STROBE_CYC(STROBE_CYC), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .is_write(eng_wr),
        .rdata(bus_rdata), .idle(eng_idle), .done(eng_done),
        .cs_n(bus_cs_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n), .rdata_q(eng_rdata)
    );

    conv_result_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .wide(cfg_q.wide), .rdata(eng_rdata),
        .lo_we((state == ST_RDLO) && eng_done),
        .last_we((state == ST_RDLAST) && eng_done),
        .publish(!first_q), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/conv_host_ctrl_chk.sv
// Protocol checker for conv_host_ctrl, attached by bind. It observes the bus
// pins, the output stream and the standby flag.
module conv_host_ctrl_chk #(
    parameter int DATA_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_rdy_n,
    input logic              standby_q,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    // R3: the two strobes are never low together.
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));
    // R3: a strobe is low only inside chip select.
    assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);
    // R3: chip select leads the strobe.
    assert_cs_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> ($past(bus_cs_n) == 1'b0));
    // R3: chip select trails the strobe.
    assert_cs_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> !bus_cs_n);
    // R2: a write starts only while ready is low or in standby.
    assert_write_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) |-> (!bus_rdy_n || standby_q));
    // R9: no read during a conversion.
    assert_read_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> (!bus_rdy_n || standby_q));
    // R10: a held result stays put.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind conv_host_ctrl conv_host_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_rdy_n(bus_rdy_n), .standby_q(standby_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_conv_host_ctrl.sv
`timescale 1ns/1ps
module tb_conv_host_ctrl;
    import conv_host_pkg::*;

    localparam int STROBE = 2;
    localparam int CONV_T = 20;
    localparam int CAL_T  = 30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_valid, cfg_wide, cfg_sync, stop_req, out_ready;
    logic [3:0]  cfg_opcode;
    logic [1:0]  cfg_acq;
    logic        cfg_ready, out_valid, bus_cs_n, bus_rd_n, bus_wr_n, bus_rdy_n;
    logic [12:0] out_data, bus_rdata;
    logic [7:0]  bus_wdata;

    always #2.5 clk = ~clk;

    conv_host_ctrl #(.STROBE_CYC(STROBE)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
        .cfg_opcode(cfg_opcode), .cfg_wide(cfg_wide), .cfg_sync(cfg_sync),
        .cfg_acq(cfg_acq), .stop_req(stop_req), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdy_n(bus_rdy_n)
    );

    int checks = 0, errors = 0;

    function automatic logic [12:0] sample_val(int i);
        return 13'((i * 937 + 341) & 8191);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic        m_rdy, m_stby, m_ptr, p_rd, p_wr, force_busy;
    int          m_timer, m_mode, m_idx, m_starts, m_viol;
    logic [12:0] m_data;
    logic [7:0]  m_cfg, m_start_cfg;

    assign bus_rdy_n = m_rdy | force_busy;
    assign bus_rdata = m_cfg[3] ? m_data :
                       (m_ptr ? {5'b10101, 3'b000, m_data[12:8]} : {5'b01010, m_data[7:0]});

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rdy <= 1; m_stby <= 1; m_ptr <= 0; m_timer <= 0; m_mode <= 0;
            m_data <= 0; m_idx <= 0; m_starts <= 0; m_viol <= 0;
            m_cfg <= 0; m_start_cfg <= 0; p_rd <= 1; p_wr <= 1;
        end else begin
            p_rd <= bus_rd_n;
            p_wr <= bus_wr_n;
            if (p_rd && !bus_rd_n && bus_rdy_n && !m_stby) m_viol <= m_viol + 1;
            if (p_wr && !bus_wr_n && bus_rdy_n && !m_stby) m_viol <= m_viol + 1;
            if (m_timer != 0) begin
                m_timer <= m_timer - 1;
                if (m_timer == 1) begin
                    m_rdy  <= 0;
                    m_mode <= 0;
                    if (m_mode == 1) begin
                        m_idx  <= m_idx + 1;
                        m_data <= sample_val(m_idx + 1);
                    end
                end
            end
            if (!p_rd && bus_rd_n) begin
                if (m_cfg[7:4] == OPC_START && !m_stby && (m_cfg[3] || m_ptr)) begin
                    m_rdy <= 1; m_timer <= CONV_T; m_mode <= 1;
                    m_starts <= m_starts + 1; m_ptr <= 0;
                end else if (!m_cfg[3]) begin
                    m_ptr <= !m_ptr;
                end
            end
            if (!p_wr && bus_wr_n) begin
                m_cfg <= bus_wdata;
                m_ptr <= 0;
                if (bus_wdata[7:4] == OPC_STANDBY) begin
                    m_stby <= 1; m_rdy <= 1; m_timer <= 0; m_mode <= 0;
                end else if (bus_wdata[7:4] == OPC_START) begin
                    m_start_cfg <= bus_wdata;
                    if (m_stby) begin
                        m_stby <= 0; m_timer <= 3; m_mode <= 2;
                    end
                end else begin
                    m_stby <= 0; m_rdy <= 1; m_timer <= CAL_T; m_mode <= 2;
                end
            end
        end
    end

    // ---------------- monitors and consumer ----------------
    int cyc = 0, rd_low = 0, cs_low = 0, rd_count = 0, wr_count = 0, wr_low = 0;
    int recv = 0, exp_idx = 1, stall_mode = 0;
    bit cur_wide = 0, prev_hold = 0;
    logic [12:0] prev_data = 0;

    always @(negedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(0, "watchdog", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (rst_n) begin
            // R3 strobe and select widths
            if (!bus_rd_n) rd_low++;
            else if (rd_low > 0) begin
                chk(rd_low == STROBE, "R3 read strobe width", rd_low, STROBE);
                rd_low = 0; rd_count++;
            end
            if (!bus_wr_n) wr_low++;
            else if (wr_low > 0) begin
                chk(wr_low == STROBE, "R3 write strobe width", wr_low, STROBE);
                wr_low = 0; wr_count++;
            end
            if (!bus_cs_n) cs_low++;
            else if (cs_low > 0) begin
                chk(cs_low == STROBE + 2, "R3 select width", cs_low, STROBE + 2);
                cs_low = 0;
            end
            // R10 held output stays stable
            if (prev_hold)
                chk(out_valid && out_data == prev_data, "R10 hold stable",
                    int'(out_data), int'(prev_data));
            begin
                bit r;
                r = (stall_mode == 0) || (cyc % stall_mode == 0);
                if (out_valid && r) begin
                    chk(out_data == sample_val(exp_idx), cur_wide ? "R8 wide value" : "R7 byte value",
                        int'(out_data), int'(sample_val(exp_idx)));
                    exp_idx++; recv++;
                end
                out_ready = r;
                prev_hold = out_valid && !r;
                prev_data = out_data;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_cfg(input logic [3:0] op, input bit w, input bit s, input logic [1:0] a);
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cfg_opcode = op; cfg_wide = w; cfg_sync = s; cfg_acq = a; cfg_valid = 1;
        @(negedge clk);
        cfg_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(cfg_ready && !out_valid)) @(negedge clk);
    endtask

    task automatic run_stream(input bit w, input bit s, input logic [1:0] a,
                              input int stall, input int nsamp, input int hold);
        int r0, s0, rd0, w0, got;
        r0 = recv; s0 = m_starts; rd0 = rd_count; w0 = wr_count;
        cur_wide = w; stall_mode = stall;
        send_cfg(OPC_START, w, s, a);
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk(wr_count == w0, "R2 write held while ready high", wr_count - w0, 0);
            force_busy = 0;
        end
        if (nsamp > 0) while (recv - r0 < nsamp) @(negedge clk);
        stop_req = 1;
        @(negedge clk);
        stop_req = 0;
        wait_idle();
        got = recv - r0;
        chk(got >= 1, "R11 stop result delivered", got, 1);
        chk(wr_count == w0 + 2, "R4 one write per request plus standby", wr_count - w0, 2);
        chk(m_start_cfg == {OPC_START, w, s, a}, s ? "R12 sync bit in byte" : "R4 byte layout",
            int'(m_start_cfg), int'({OPC_START, w, s, a}));
        chk(m_cfg[7:4] == OPC_STANDBY, "R11 standby written", int'(m_cfg[7:4]), int'(OPC_STANDBY));
        chk(m_stby == 1, "R11 converter in standby", int'(m_stby), 1);
        chk(m_starts - s0 == got, "R11 no extra start", m_starts - s0, got);
        chk(rd_count - rd0 == (w ? 1 : 2) * (got + 1), "R6 reads per run",
            rd_count - rd0, (w ? 1 : 2) * (got + 1));
        chk(m_viol == 0, "R9 no access during conversion", m_viol, 0);
    endtask

    initial begin
        int w0;
        rst_n = 0; cfg_valid = 0; cfg_opcode = 0; cfg_wide = 0; cfg_sync = 0;
        cfg_acq = 0; stop_req = 0; out_ready = 1; force_busy = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(bus_cs_n && bus_rd_n && bus_wr_n, "R1 strobes idle", int'({bus_cs_n, bus_rd_n, bus_wr_n}), 7);
        chk(!out_valid, "R1 output empty", int'(out_valid), 0);
        chk(cfg_ready, "R1 ready for request", int'(cfg_ready), 1);

        // R5: calibrate from standby; idle only once it has finished.
        w0 = wr_count;
        send_cfg(OPC_CAL, 0, 0, 2'd0);
        wait_idle();
        chk(wr_count == w0 + 1, "R4 single write", wr_count - w0, 1);
        chk(m_cfg == 8'h10, "R4 calibrate byte", int'(m_cfg), 16);
        chk(m_timer == 0 && !m_rdy, "R5 idle after calibration end", m_timer, 0);
        chk(rd_count == 0, "R5 no reads after calibrate", rd_count, 0);

        // R2: ready forced high outside standby holds back the write.
        force_busy = 1;
        run_stream(1, 0, 2'd2, 3, 4, 30);
        run_stream(0, 0, 2'd1, 0, 5, 0);
        run_stream(0, 1, 2'd3, 4, 4, 0);
        run_stream(1, 1, 2'd0, 2, 3, 0);
        run_stream(0, 0, 2'd2, 0, 0, 0);
        run_stream(1, 0, 2'd1, 5, 0, 0);
        chk(exp_idx - 1 == m_idx, "R10 every result delivered", exp_idx - 1, m_idx);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule